// File: doc/BRIEF.md
# Double-Precision to Fixed-Point Saturating Converter

This unit turns one IEEE-754 binary64 operand per cycle into a fixed-point value. A three-bit `mode` input picks the target format: signed or unsigned 32-bit integer, signed or unsigned 64-bit integer, or a 32-bit unsigned fraction. For the integer targets, `rnd_zero` picks the rounding. When it is low the unit rounds to nearest with ties going to even. When it is high the unit truncates toward zero.

If a result does not fit the target, it is pinned to that target's limit and three status flags are raised together. The flags are overflow, inexact and guard. For 32-bit targets the caller supplies the previous 64-bit destination word. Only its low half is replaced, and its high half passes through unchanged.

Internally the operand is split into sign, exponent and mantissa. The mantissa is aligned against a double-width fixed-point frame, which yields an integer part plus guard and sticky bits. The integer part is rounded, then clamped against the limit for the selected mode, and the result is registered.

Top module: `dbl2fix_sat`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` and the three flags change only in that cycle and otherwise hold their value. Synchronous reset clears `out_valid`, `result` and all flags to zero.
- R2: The mode codes are: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit, 4 = unsigned 32-bit fraction. Codes 5 to 7 behave as code 0. An in-range input yields its exact integer value.
- R3: With `rnd_zero` = 0, integer modes round to nearest, and a tie goes to the even neighbour. With `rnd_zero` = 1, they drop the fractional part. Signed modes round the magnitude and then negate it when the sign bit is set.
- R4: Signed 32-bit mode pins results above the range to 0x7FFFFFFF and results below it to 0x80000000. The range check is applied after rounding, and infinities are handled the same way.
- R5: Unsigned 32-bit mode pins results above the range to 0xFFFFFFFF. A negative input gives 0, with inexact set only when the input magnitude is nonzero, and with overflow and guard clear.
- R6: Signed 64-bit mode pins results to 2^63-1 on the positive side and to -2^63 on the negative side. -2^63 itself converts without any flag.
- R7: Unsigned 64-bit mode pins values of 2^64 and above to all ones. Negative inputs follow the zero rule of R5.
- R8: Fraction mode computes trunc(min(x, (2^32-1)/2^32) * 2^32) into 32 bits and always truncates, whatever `rnd_zero` says. Negative inputs follow R5.
- R9: Whenever a result is pinned to a limit, `flag_ovf`, `flag_inx` and `flag_grd` are all 1.
- R10: When a result is neither pinned, NaN, nor the negative-to-unsigned case, `flag_ovf` is 0. `flag_grd` is the first bit below the integer LSB. `flag_inx` is 1 if any bit below the LSB is nonzero.
- R11: A NaN input (exponent all ones, nonzero fraction) gives a result field of 0, with `flag_ovf` = 1 and the other two flags 0.
- R12: In modes 0, 1 and 4 (and 5 to 7), `result[63:32]` equals `old_dest[63:32]` of the same request. Modes 2 and 3 replace all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A conversion request is present |
| mode | input | 3 | Target format code |
| rnd_zero | input | 1 | 1 = truncate, 0 = round to nearest even |
| op | input | 64 | binary64 operand |
| old_dest | input | 64 | Previous destination word, merged for 32-bit targets |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Converted value |
| flag_ovf | output | 1 | Overflow / invalid |
| flag_inx | output | 1 | Inexact |
| flag_grd | output | 1 | Guard bit |

## Verification
The bench builds the unit with its default parameters: an 11-bit exponent, a 52-bit fraction and a 64-bit integer frame. These are the only values that match binary64, and they allow each of the signed and unsigned limits to be hit exactly. The stimulus includes values just past each limit, such as 2^31, 2^32, 2^63 and 2^64, and a value that crosses the 32-bit signed limit only because of rounding. Subnormals exercise the sticky path, where the shift exceeds the frame, and a value of 2^-33 in fraction mode lands exactly on the guard bit.

// File: rtl/dbl2fix_pkg.sv
package dbl2fix_pkg;

  typedef enum logic [2:0] {
    CV_S32 = 3'd0,
    CV_U32 = 3'd1,
    CV_S64 = 3'd2,
    CV_U64 = 3'd3,
    CV_UFR = 3'd4
  } cv_mode_e;

  typedef struct packed {
    logic ovf;
    logic inx;
    logic grd;
  } cv_flags_t;

endpackage

// File: rtl/dbl2fix_align.sv
module dbl2fix_align #(
  parameter int EXP_W      = 11,
  parameter int FRC_W      = 52,
  parameter int INT_W      = 64,
  parameter int FRAC_SCALE = 32
) (
  input  logic [EXP_W+FRC_W:0] op,
  input  logic                 frac_mode,
  output logic [INT_W-1:0]     mag,
  output logic                 guard,
  output logic                 sticky,
  output logic                 big,
  output logic                 is_nan,
  output logic                 sign,
  output logic                 nonzero
);
  localparam int MW    = FRC_W + 1;
  localparam int WIDE  = 2 * INT_W;
  localparam int TOPSH = INT_W - MW;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int SHW   = EXP_W + 8;
  localparam int SHC   = $clog2(WIDE);

  logic [EXP_W-1:0]      expf;
  logic [FRC_W-1:0]      frc;
  logic [EXP_W-1:0]      exp_eff;
  logic [MW-1:0]         mant;
  logic signed [SHW-1:0] sh;
  logic signed [SHW-1:0] rr;
  logic [WIDE-1:0]       base;
  logic [WIDE-1:0]       shifted;
  logic                  lost;
  logic                  is_inf;

  assign expf    = op[FRC_W +: EXP_W];
  assign frc     = op[FRC_W-1:0];
  assign sign    = op[EXP_W+FRC_W];
  assign nonzero = |op[EXP_W+FRC_W-1:0];
  assign is_nan  = (&expf) && (|frc);
  assign is_inf  = (&expf) && !(|frc);
  assign exp_eff = (expf == '0) ? EXP_W'(1) : expf;
  assign mant    = {(expf != '0), frc};
  assign base    = {mant, {(WIDE-MW){1'b0}}};

  always_comb begin
    sh = $signed({{(SHW-EXP_W){1'b0}}, exp_eff})
         + (frac_mode ? SHW'(FRAC_SCALE) : SHW'(0))
         - SHW'(BIAS + FRC_W);
    rr  = SHW'(TOPSH) - sh;
    big = is_inf || (sh > SHW'(TOPSH));
    shifted = '0;
    lost    = 1'b0;
    if (!big) begin
      if (rr >= SHW'(WIDE)) begin
        shifted = '0;
        lost    = |mant;
      end else begin
        shifted = base >> rr[SHC-1:0];
        lost    = |(base & ~({WIDE{1'b1}} << rr[SHC-1:0]));
      end
    end
  end

  assign mag    = shifted[WIDE-1:INT_W];
  assign guard  = shifted[INT_W-1];
  assign sticky = (|shifted[INT_W-2:0]) || lost;

endmodule

// File: rtl/dbl2fix_round.sv
module dbl2fix_round #(
  parameter int INT_W = 64
) (
  input  logic [INT_W-1:0] mag,
  input  logic             guard,
  input  logic             sticky,
  input  logic             nearest,
  output logic [INT_W:0]   mag_r
);
  logic bump;

  assign bump  = nearest && guard && (sticky || mag[0]);
  assign mag_r = {1'b0, mag} + {{INT_W{1'b0}}, bump};

endmodule

// File: rtl/dbl2fix_clamp.sv
module dbl2fix_clamp
  import dbl2fix_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  cv_mode_e         mode,
  input  logic [INT_W:0]   mag_r,
  input  logic             big,
  input  logic             sign,
  input  logic             is_nan,
  input  logic             nonzero,
  input  logic             guard,
  input  logic             sticky,
  output logic [INT_W-1:0] res,
  output cv_flags_t        flags
);
  localparam int HALF = INT_W / 2;
  localparam logic [INT_W:0] U32_MAX = {{(INT_W-HALF+1){1'b0}}, {HALF{1'b1}}};
  localparam logic [INT_W:0] S32_MAX = {{(INT_W-HALF+2){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [INT_W:0] S32_NEG = S32_MAX + 1'b1;
  localparam logic [INT_W:0] S64_MAX = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] S64_NEG = S64_MAX + 1'b1;

  logic             over;
  logic             neg_uns;
  logic [INT_W-1:0] val;

  always_comb begin
    over    = 1'b0;
    neg_uns = 1'b0;
    val     = '0;
    case (mode)
      CV_U32, CV_UFR: begin
        if (sign) neg_uns = 1'b1;
        else begin
          over = big || (mag_r > U32_MAX);
          val  = over ? U32_MAX[INT_W-1:0] : mag_r[INT_W-1:0];
        end
      end
      CV_S64: begin
        if (sign) begin
          over = big || (mag_r > S64_NEG);
          val  = over ? S64_NEG[INT_W-1:0] : -mag_r[INT_W-1:0];
        end else begin
          over = big || (mag_r > S64_MAX);
          val  = over ? S64_MAX[INT_W-1:0] : mag_r[INT_W-1:0];
        end
      end
      CV_U64: begin
        if (sign) neg_uns = 1'b1;
        else begin
          over = big || mag_r[INT_W];
          val  = over ? {INT_W{1'b1}} : mag_r[INT_W-1:0];
        end
      end
      default: begin
        if (sign) begin
          over = big || (mag_r > S32_NEG);
          val  = over ? S32_NEG[INT_W-1:0] : -mag_r[INT_W-1:0];
        end else begin
          over = big || (mag_r > S32_MAX);
          val  = over ? S32_MAX[INT_W-1:0] : mag_r[INT_W-1:0];
        end
      end
    endcase

    if (is_nan) begin
      res   = '0;
      flags = '{ovf: 1'b1, inx: 1'b0, grd: 1'b0};
    end else if (neg_uns) begin
      res   = '0;
      flags = '{ovf: 1'b0, inx: nonzero, grd: 1'b0};
    end else if (over) begin
      res   = val;
      flags = '{ovf: 1'b1, inx: 1'b1, grd: 1'b1};
    end else begin
      res   = val;
      flags = '{ovf: 1'b0, inx: guard || sticky, grd: guard};
    end
  end

endmodule

// File: rtl/dbl2fix_sat.sv
module dbl2fix_sat
  import dbl2fix_pkg::*;
#(
  parameter int EXP_W      = 11,
  parameter int FRC_W      = 52,
  parameter int INT_W      = 64,
  parameter int FRAC_SCALE = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             mode,
  input  logic                   rnd_zero,
  input  logic [EXP_W+FRC_W:0]   op,
  input  logic [INT_W-1:0]       old_dest,
  output logic                   out_valid,
  output logic [INT_W-1:0]       result,
  output logic                   flag_ovf,
  output logic                   flag_inx,
  output logic                   flag_grd
);
  localparam int HALF = INT_W / 2;
  localparam logic [INT_W-1:0] HI_MASK = {{HALF{1'b1}}, {(INT_W-HALF){1'b0}}};

  cv_mode_e         md;
  logic             frac_mode;
  logic             is32;
  logic             nearest;
  logic [INT_W-1:0] mag;
  logic [INT_W:0]   mag_r;
  logic             guard, sticky, big, is_nan, sign, nonzero;
  logic [INT_W-1:0] res;
  cv_flags_t        flags;
  logic [INT_W-1:0] merged;

  assign md        = cv_mode_e'(mode);
  assign frac_mode = (md == CV_UFR);
  assign is32      = !(md == CV_S64 || md == CV_U64);
  assign nearest   = !rnd_zero && !frac_mode;

  dbl2fix_align #(
    .EXP_W(EXP_W), .FRC_W(FRC_W), .INT_W(INT_W), .FRAC_SCALE(FRAC_SCALE)
  ) u_align (
    .op(op), .frac_mode(frac_mode), .mag(mag), .guard(guard),
    .sticky(sticky), .big(big), .is_nan(is_nan), .sign(sign), .nonzero(nonzero)
  );

  dbl2fix_round #(.INT_W(INT_W)) u_round (
    .mag(mag), .guard(guard), .sticky(sticky), .nearest(nearest), .mag_r(mag_r)
  );

  dbl2fix_clamp #(.INT_W(INT_W)) u_clamp (
    .mode(md), .mag_r(mag_r), .big(big), .sign(sign), .is_nan(is_nan),
    .nonzero(nonzero), .guard(guard), .sticky(sticky), .res(res), .flags(flags)
  );

  assign merged = is32 ? ((old_dest & HI_MASK) | {{(INT_W-HALF){1'b0}}, res[HALF-1:0]})
                       : res;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_ovf  <= 1'b0;
      flag_inx  <= 1'b0;
      flag_grd  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= merged;
        flag_ovf <= flags.ovf;
        flag_inx <= flags.inx;
        flag_grd <= flags.grd;
      end
    end
  end

endmodule

// File: rtl/dbl2fix_sat_chk.sv
module dbl2fix_sat_chk #(
  parameter int EXP_W = 11,
  parameter int FRC_W = 52,
  parameter int INT_W = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [2:0]               mode,
  input logic [EXP_W+FRC_W:0]     op,
  input logic [INT_W-1:INT_W/2]   old_hi,
  input logic                     out_valid,
  input logic [INT_W-1:0]         result,
  input logic                     flag_ovf,
  input logic                     flag_inx,
  input logic                     flag_grd
);
  localparam int HALF = INT_W / 2;

  logic nan_in, wide_mode, uns_small;
  assign nan_in    = (&op[FRC_W +: EXP_W]) && (|op[FRC_W-1:0]);
  assign wide_mode = (mode == 3'd2) || (mode == 3'd3);
  assign uns_small = (mode == 3'd1) || (mode == 3'd4);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_ovf)
                   && $stable(flag_inx) && $stable(flag_grd)));
  assert_upper_kept_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_mode) |=> (result[INT_W-1:HALF] == $past(old_hi)));
  assert_clamp_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_ovf) |-> (flag_inx == flag_grd));
  assert_guard_inexact_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_grd) |-> flag_inx);
  assert_neg_unsigned_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && uns_small && op[EXP_W+FRC_W] && !nan_in) |=>
      (result[HALF-1:0] == '0 && !flag_ovf));
  assert_nan_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nan_in) |=> (flag_ovf && !flag_inx && result[HALF-1:0] == '0));
  assert_s32_pos_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd0 && !op[EXP_W+FRC_W]) |=> !result[HALF-1]);

endmodule

bind dbl2fix_sat dbl2fix_sat_chk #(
  .EXP_W(EXP_W), .FRC_W(FRC_W), .INT_W(INT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .op(op),
  .old_hi(old_dest[INT_W-1:INT_W/2]), .out_valid(out_valid), .result(result),
  .flag_ovf(flag_ovf), .flag_inx(flag_inx), .flag_grd(flag_grd)
);

// File: tb/test_dbl2fix_sat.sv
module test_dbl2fix_sat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic        rnd_zero = 1'b0;
  logic [63:0] op = '0;
  logic [63:0] old_dest = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_ovf, flag_inx, flag_grd;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dbl2fix_sat i_dbl2fix_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .rnd_zero(rnd_zero),
    .op(op), .old_dest(old_dest), .out_valid(out_valid), .result(result),
    .flag_ovf(flag_ovf), .flag_inx(flag_inx), .flag_grd(flag_grd)
  );

  localparam logic [63:0] OLD = 64'hA5A5A5A5_5A5A5A5A;
  localparam int NV = 32;
  // {req[3:0], mode[2:0], rnd_zero, op[63:0], expected[63:0], {ovf,inx,grd}}
  localparam logic [138:0] VEC [NV] = '{
    {4'd2,  3'd0, 1'b0, 64'h3FF0000000000000, 64'hA5A5A5A5_00000001, 3'b000}, // R2 1.0
    {4'd3,  3'd0, 1'b0, 64'h4004000000000000, 64'hA5A5A5A5_00000002, 3'b011}, // R3 2.5 tie
    {4'd3,  3'd0, 1'b0, 64'h400C000000000000, 64'hA5A5A5A5_00000004, 3'b011}, // R3 3.5 tie
    {4'd3,  3'd0, 1'b1, 64'h4006000000000000, 64'hA5A5A5A5_00000002, 3'b011}, // R3 2.75 trunc
    {4'd3,  3'd0, 1'b0, 64'h4006000000000000, 64'hA5A5A5A5_00000003, 3'b011}, // R3 2.75 near
    {4'd3,  3'd0, 1'b0, 64'hBFF8000000000000, 64'hA5A5A5A5_FFFFFFFE, 3'b011}, // R3 -1.5
    {4'd3,  3'd0, 1'b1, 64'hBFF8000000000000, 64'hA5A5A5A5_FFFFFFFF, 3'b011}, // R3 -1.5 trunc
    {4'd3,  3'd0, 1'b0, 64'h3FE0000000000000, 64'hA5A5A5A5_00000000, 3'b011}, // R3 0.5
    {4'd4,  3'd0, 1'b0, 64'hC1E0000000000000, 64'hA5A5A5A5_80000000, 3'b000}, // R4 -2^31
    {4'd9,  3'd0, 1'b0, 64'hC1F0000000000000, 64'hA5A5A5A5_80000000, 3'b111}, // R9 -2^32
    {4'd9,  3'd0, 1'b0, 64'h41F0000000000000, 64'hA5A5A5A5_7FFFFFFF, 3'b111}, // R9 2^32
    {4'd4,  3'd0, 1'b0, 64'h41DFFFFFFFE00000, 64'hA5A5A5A5_7FFFFFFF, 3'b111}, // R4 round over
    {4'd3,  3'd0, 1'b1, 64'h41DFFFFFFFE00000, 64'hA5A5A5A5_7FFFFFFF, 3'b011}, // R3 trunc
    {4'd4,  3'd0, 1'b0, 64'h7FF0000000000000, 64'hA5A5A5A5_7FFFFFFF, 3'b111}, // R4 +inf
    {4'd11, 3'd0, 1'b0, 64'h7FF8000000000000, 64'hA5A5A5A5_00000000, 3'b100}, // R11 NaN
    {4'd5,  3'd1, 1'b0, 64'h41F0000000000000, 64'hA5A5A5A5_FFFFFFFF, 3'b111}, // R5 2^32
    {4'd5,  3'd1, 1'b0, 64'h41E0000000000000, 64'hA5A5A5A5_80000000, 3'b000}, // R5 2^31
    {4'd5,  3'd1, 1'b0, 64'hBFF8000000000000, 64'hA5A5A5A5_00000000, 3'b010}, // R5 negative
    {4'd5,  3'd1, 1'b0, 64'h8000000000000000, 64'hA5A5A5A5_00000000, 3'b000}, // R5 -0
    {4'd6,  3'd2, 1'b0, 64'h43E0000000000000, 64'h7FFFFFFFFFFFFFFF, 3'b111}, // R6 2^63
    {4'd6,  3'd2, 1'b0, 64'hC3E0000000000000, 64'h8000000000000000, 3'b000}, // R6 -2^63
    {4'd6,  3'd2, 1'b0, 64'hC004000000000000, 64'hFFFFFFFFFFFFFFFE, 3'b011}, // R6 -2.5
    {4'd7,  3'd3, 1'b0, 64'h43E0000000000000, 64'h8000000000000000, 3'b000}, // R7 2^63
    {4'd7,  3'd3, 1'b0, 64'h43F0000000000000, 64'hFFFFFFFFFFFFFFFF, 3'b111}, // R7 2^64
    {4'd7,  3'd3, 1'b1, 64'h4330000000000001, 64'h0010000000000001, 3'b000}, // R7 2^52+1
    {4'd8,  3'd4, 1'b0, 64'h3FE0000000000000, 64'hA5A5A5A5_80000000, 3'b000}, // R8 0.5
    {4'd8,  3'd4, 1'b0, 64'h3FE8000000000000, 64'hA5A5A5A5_C0000000, 3'b000}, // R8 0.75
    {4'd8,  3'd4, 1'b0, 64'h3FF0000000000000, 64'hA5A5A5A5_FFFFFFFF, 3'b111}, // R8 1.0 clamp
    {4'd8,  3'd4, 1'b0, 64'h3DE0000000000000, 64'hA5A5A5A5_00000000, 3'b011}, // R8 2^-33 trunc
    {4'd10, 3'd0, 1'b0, 64'h0000000000000001, 64'hA5A5A5A5_00000000, 3'b010}, // R10 subnormal
    {4'd2,  3'd5, 1'b0, 64'h4004000000000000, 64'hA5A5A5A5_00000002, 3'b011}, // R2 reserved code
    {4'd11, 3'd2, 1'b0, 64'h7FF8000000000000, 64'h0000000000000000, 3'b100}  // R11 NaN 64-bit
  };

  task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [2:0] m, input logic rz, input logic [63:0] a,
                         input logic [63:0] old);
    @(negedge clk);
    mode = m; rnd_zero = rz; op = a; old_dest = old; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {out_valid, result, flag_ovf, flag_inx, flag_grd}, 67'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      convert(VEC[i][134:132], VEC[i][131], VEC[i][130:67], OLD);
      check($sformatf("R%0d vec%0d", VEC[i][138:135], i),
            {out_valid, result, flag_ovf, flag_inx, flag_grd},
            {1'b1, VEC[i][66:0]});
    end

    // R12 merge keeps upper half of a different old word; 64-bit mode ignores it
    convert(3'd0, 1'b0, 64'h3FF0000000000000, 64'h12345678_9ABCDEF0);
    check("R12 merge 32", {3'b000, result}, {3'b000, 64'h12345678_00000001});
    convert(3'd2, 1'b0, 64'h3FF0000000000000, 64'h12345678_9ABCDEF0);
    check("R12 full 64", {3'b000, result}, {3'b000, 64'h0000000000000001});

    // R1 outputs hold while idle even as inputs change
    convert(3'd3, 1'b0, 64'h43F0000000000000, 64'h0);
    @(negedge clk);
    mode = 3'd0; op = 64'h3FF0000000000000; old_dest = '0;
    repeat (3) @(negedge clk);
    check("R1 hold", {out_valid, result, flag_ovf, flag_inx, flag_grd},
          {1'b0, 64'hFFFFFFFFFFFFFFFF, 3'b111});

    // R1 reset clears a loaded result
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", {out_valid, result, flag_ovf, flag_inx, flag_grd}, 67'd0);
    rst = 1'b0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule